// File: doc/BRIEF.md
# Serial Register Port with Chained Shift-Out and Readback

This block is the serial front end of a four-channel converter's register file. A host drives a chip-select, a serial clock and a data line. While the chip-select is low, the block samples one bit on every falling edge of the serial clock into a 24-bit frame, most significant bit first. When the chip-select rises, the block decodes the frame. A complete write frame to a mapped address becomes a one-cycle strobe on a register-file write port. A read frame selects an address on the read port. The contents of that address are shifted out on the serial output during the next frame.

The serial output is the top bit of the frame shift register. Bits clocked in beyond the 24th therefore leave on it in order, and several devices can be chained output to input. All serial inputs are brought into the core clock domain through synchronisers and handled as sampled edges. The output drive is split into a data bit and an enable, which an external pad turns into a tristate pin. An input from the command register turns the output drive off.

Top module: `spi_reg_if`

## Requirements
- R1: Frame layout with the first bit sent as bit 23: bit 23 = read flag (1 = read), bits 22:20 reserved and ignored, bits 19:16 = address, bits 15:0 = data. A write frame (bit 23 = 0) of exactly 24 falling SCLK edges to a mapped address produces exactly one `wr_en_o` pulse after CS rises, with that address and data.
- R2: If CS rises after fewer than 24 falling SCLK edges, the frame is dropped: no write strobe and no read request.
- R3: If more than 24 falling edges occur while CS is low, only the last 24 bits received are decoded.
- R4: While CS is high, SCLK and SDI have no effect (no strobe) and `sdo_oe_o` is 0.
- R5: During a frame, after k falling edges with k >= 24, `sdo_o` carries the bit received on edge k-23. This forwards overflow bits in order for chaining.
- R6: While `dsdo_i` is 1, `sdo_oe_o` is 0.
- R7: A read frame causes no write strobe and sets `rd_addr_o` to its address. During the first 24 bits of the next frame, `sdo_o` carries {1, 000, address, `rd_data_i`}, MSB first. This is the same layout as a write.
- R8: A frame that does not follow a committed read frame shifts out 24 zero bits before any overflow bits. A pending read is consumed by the next CS falling edge, whether or not that frame is later dropped.
- R9: A write frame to an address at or above REG_COUNT (default 9, so 9..15 are unmapped) produces no write strobe.
- R10: While `rst_ni` is low, CS, SCLK and SDI are ignored and the outputs are idle (`wr_en_o` = 0, `sdo_oe_o` = 0). After reset, no read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, data sampled on falling edges |
| cs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (0 when not driven) |
| sdo_oe_o | output | 1 | Output enable for the SDO pad |
| dsdo_i | input | 1 | 1 turns the serial output drive off |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 4 | Write address |
| wr_data_o | output | 16 | Write data |
| rd_addr_o | output | 4 | Address of the latest committed read |
| rd_data_i | input | 16 | Register-file data at `rd_addr_o` |

## Verification
The assertions check on every cycle that the output enable stays off while CS is high or the drive is disabled. They also check that the shift register holds while CS is high, that the edge count saturates rather than wrapping, that write strobes are single pulses to mapped addresses, and that a captured read never coincides with a write. Only the bench scenarios can show the actual bit order on SDO. These include the readback word in the frame after a read, forwarding of overflow bits in long frames, the dropping of short frames, decoding of the last 24 bits, and that decoded addresses and data reach the write port intact.

// File: rtl/spi_reg_if_pkg.sv
package spi_reg_if_pkg;
  localparam int unsigned DEF_ADDR_W    = 4;
  localparam int unsigned DEF_DATA_W    = 16;
  localparam int unsigned DEF_RSV_W     = 3;
  localparam int unsigned DEF_REG_COUNT = 9;
  localparam int unsigned DEF_SYNC      = 2;

  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_fall;
    logic cs_high;
  } spi_evt_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= RST_VAL;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[k] <= RST_VAL;
        else         stage_q[k] <= stage_q[k-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge_detect.sv
module spi_edge_detect
  import spi_reg_if_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_s_i,
  input  logic     cs_n_s_i,
  output spi_evt_t evt_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_n_s_i;
    end
  end

  always_comb begin
    evt_o.cs_high   = cs_n_s_i;
    evt_o.cs_fall   = cs_q & ~cs_n_s_i;
    evt_o.cs_rise   = ~cs_q & cs_n_s_i;
    // falling SCLK only counts inside an open frame
    evt_o.sclk_fall = sclk_q & ~sclk_s_i & ~cs_n_s_i & ~cs_q;
  end

  a_r4_no_shift_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |-> !evt_o.sclk_fall);
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               shift_i,
  input  logic               cs_high_i,
  input  logic               bit_i,
  input  logic [FRAME_W-1:0] preload_i,
  output logic [FRAME_W-1:0] sr_o,
  output logic               full_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      sr_q  <= preload_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[FRAME_W-2:0], bit_i};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sr_o   = sr_q;
  assign full_o = (cnt_q == CNT_MAX);

  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_high_i |=> $stable(sr_q));
  a_r3_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && shift_i && !start_i) |=> full_o);
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/spi_frame_decode.sv
module spi_frame_decode #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RSV_W     = 3,
  parameter int unsigned REG_COUNT = 9
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_i,
  input  logic                             start_i,
  input  logic [1+RSV_W+ADDR_W+DATA_W-1:0] frame_i,
  output logic                             wr_en_o,
  output logic [ADDR_W-1:0]                wr_addr_o,
  output logic [DATA_W-1:0]                wr_data_o,
  output logic                             rd_pend_o,
  output logic [ADDR_W-1:0]                rd_addr_o
);
  localparam int unsigned FRAME_W  = 1 + RSV_W + ADDR_W + DATA_W;
  localparam int unsigned RW_POS   = FRAME_W - 1;
  localparam int unsigned ADDR_LSB = DATA_W;
  localparam logic [ADDR_W:0] REG_LIMIT = (ADDR_W+1)'(REG_COUNT);

  logic              is_read;
  logic              mapped;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;

  assign is_read = frame_i[RW_POS];
  assign f_addr  = frame_i[ADDR_LSB +: ADDR_W];
  assign f_data  = frame_i[DATA_W-1:0];
  assign mapped  = ({1'b0, f_addr} < REG_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= commit_i & ~is_read & mapped;
      if (commit_i & ~is_read & mapped) begin
        wr_addr_o <= f_addr;
        wr_data_o <= f_data;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_o <= 1'b0;
      rd_addr_o <= '0;
    end else if (commit_i && is_read) begin
      rd_pend_o <= 1'b1;
      rd_addr_o <= f_addr;
    end else if (start_i) begin
      rd_pend_o <= 1'b0;
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  a_r9_mapped_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ({1'b0, wr_addr_o} < REG_LIMIT));
  a_r7_read_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_pend_o) |-> !wr_en_o);
endmodule

// File: rtl/spi_sdo_drive.sv
module spi_sdo_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_high_i,
  input  logic dsdo_i,
  input  logic msb_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic drive;

  assign drive    = ~cs_high_i & ~dsdo_i;
  assign sdo_oe_o = drive;
  assign sdo_o    = msb_i & drive;

  a_r6_drive_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsdo_i |-> (!sdo_oe_o && !sdo_o));
  a_r4_idle_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_high_i |-> !sdo_oe_o);
endmodule

// File: rtl/spi_reg_if.sv
module spi_reg_if
  import spi_reg_if_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned RSV_W       = DEF_RSV_W,
  parameter int unsigned REG_COUNT   = DEF_REG_COUNT,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              dsdo_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int unsigned FRAME_W = 1 + RSV_W + ADDR_W + DATA_W;

  logic [2:0]         pins_s;
  spi_evt_t           evt;
  logic [FRAME_W-1:0] sr;
  logic [FRAME_W-1:0] preload;
  logic               full;
  logic               commit;
  logic               rd_pend;

  spi_in_sync #(
    .STAGES (SYNC_STAGES),
    .W      (3),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, sdi_i}),
    .q_o   (pins_s)
  );

  spi_edge_detect u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(pins_s[2]),
    .cs_n_s_i(pins_s[1]),
    .evt_o   (evt)
  );

  // readback word uses the write layout with the read flag set
  assign preload = rd_pend ? {1'b1, {RSV_W{1'b0}}, rd_addr_o, rd_data_i} : '0;

  spi_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (evt.cs_fall),
    .shift_i  (evt.sclk_fall),
    .cs_high_i(evt.cs_high),
    .bit_i    (pins_s[0]),
    .preload_i(preload),
    .sr_o     (sr),
    .full_o   (full)
  );

  assign commit = evt.cs_rise & full;

  spi_frame_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RSV_W    (RSV_W),
    .REG_COUNT(REG_COUNT)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .start_i  (evt.cs_fall),
    .frame_i  (sr),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .rd_pend_o(rd_pend),
    .rd_addr_o(rd_addr_o)
  );

  spi_sdo_drive u_sdo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_high_i(evt.cs_high),
    .dsdo_i   (dsdo_i),
    .msb_i    (sr[FRAME_W-1]),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  a_r2_commit_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(full));
  a_r2_pend_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_pend) |-> $past(full));
endmodule

// File: tb/spi_reg_if_tb_top.sv
module spi_reg_if_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, dsdo = 1'b0;
  logic sdo, sdo_oe, wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [15:0] regs [16];

  int checks = 0, fails = 0;
  int wr_cnt = 0;
  logic [3:0]  last_wa;
  logic [15:0] last_wd;
  logic        oe_seen;
  logic [63:0] got;
  logic [63:0] sbits;
  logic        pend = 1'b0;
  logic [3:0]  pend_addr = '0;
  bit          done = 0;

  always #10 clk = ~clk;

  assign rd_data = regs[rd_addr];

  spi_reg_if dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .dsdo_i(dsdo), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      wr_cnt++;
      last_wa = wr_addr;
      last_wd = wr_data;
      regs[wr_addr] = wr_data;
    end
    if (sdo_oe) oe_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n falling edges; if n >= 24, last 24 bits are frame, leading bits random
  task automatic run_frame(input int n, input logic dis, input logic [23:0] frame, input string req);
    logic [23:0] pre;
    logic [63:0] expv;
    int          wc0;
    bit          ok_sdo;
    pre  = pend ? {1'b1, 3'b000, pend_addr, regs[pend_addr]} : 24'h0;
    pend = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (n >= 24) sbits[i] = (i < n - 24) ? 1'($urandom) : frame[23 - (i - (n - 24))];
      else         sbits[i] = frame[23 - i];
    end
    wc0 = wr_cnt;
    oe_seen = 1'b0;
    dsdo = dis;
    @(negedge clk); cs_n = 1'b0;
    idle(6);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sdi = sbits[i]; sclk = 1'b1;
      idle(4);
      got[i] = sdo;
      sclk = 1'b0;
      idle(4);
    end
    idle(2);
    cs_n = 1'b1;
    idle(8);
    expv = '0;
    for (int i = 0; i < n; i++) expv[i] = (i < 24) ? pre[23 - i] : sbits[i - 24];
    ok_sdo = 1'b1;
    for (int i = 0; i < n; i++) if (got[i] !== expv[i]) ok_sdo = 1'b0;
    if (dis) chk(!oe_seen && got == 0, "R6 dsdo blocks sdo", {63'h0, oe_seen}, 64'h0);
    else     chk(ok_sdo, req, got, expv);
    if (n >= 24 && !frame[23] && frame[19:16] < 4'd9) begin
      chk(wr_cnt == wc0 + 1 && last_wa == frame[19:16] && last_wd == frame[15:0],
          "R1/R3 write strobe", {wr_cnt - wc0, 12'h0, last_wa, last_wd},
          {32'd1, 12'h0, frame[19:16], frame[15:0]});
    end else begin
      chk(wr_cnt == wc0, "R2/R7/R9 no write strobe", 64'(wr_cnt - wc0), 64'h0);
    end
    if (n >= 24 && frame[23]) begin
      pend = 1'b1; pend_addr = frame[19:16];
      chk(rd_addr == frame[19:16], "R7 read address", 64'(rd_addr), 64'(frame[19:16]));
    end
    dsdo = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    for (int i = 0; i < 16; i++) regs[i] = 16'($urandom);
    // R10: activity during reset is ignored
    cs_n = 1'b0;
    repeat (30) begin
      @(negedge clk); sclk = ~sclk; sdi = 1'($urandom);
    end
    chk(wr_en == 0 && sdo_oe == 0, "R10 idle in reset", {62'h0, wr_en, sdo_oe}, 64'h0);
    @(negedge clk); cs_n = 1'b1; sclk = 1'b0;
    idle(5);
    rst_ni = 1'b1;
    idle(5);
    chk(wr_cnt == 0 && sdo_oe == 0, "R10 after reset", {32'(wr_cnt), 31'h0, sdo_oe}, 64'h0);
    // R8/R10: no pending read after reset, write reg 3
    run_frame(24, 1'b0, {1'b0, 3'b000, 4'd3, 16'hBEEF}, "R8 zero preload");
    // R7: read 3, then NOP-style read of 0 returns reg 3
    run_frame(24, 1'b0, {1'b1, 3'b000, 4'd3, 16'h0000}, "R8 zero preload");
    run_frame(24, 1'b0, {1'b1, 3'b000, 4'd0, 16'h1234}, "R7 readback word");
    run_frame(24, 1'b0, {1'b0, 3'b000, 4'd0, 16'h0000}, "R7 readback of reg0");
    // R1: reserved bits ignored
    run_frame(24, 1'b0, {1'b0, 3'b111, 4'd8, 16'hA5C3}, "R1 reserved ignored");
    // R2: short frame dropped, R9 unmapped
    run_frame(10, 1'b0, {1'b0, 3'b000, 4'd2, 16'h1111}, "R2 short frame sdo");
    run_frame(23, 1'b0, {1'b0, 3'b000, 4'd2, 16'h2222}, "R2 short frame sdo");
    run_frame(24, 1'b0, {1'b0, 3'b000, 4'd12, 16'h3333}, "R9 unmapped");
    run_frame(24, 1'b0, {1'b0, 3'b000, 4'd15, 16'h4444}, "R9 unmapped");
    // R3/R5: long frames, overflow forwarded
    run_frame(40, 1'b0, {1'b0, 3'b000, 4'd5, 16'h5A5A}, "R5 overflow forward");
    run_frame(48, 1'b0, {1'b1, 3'b000, 4'd5, 16'h0000}, "R5 overflow forward");
    run_frame(30, 1'b0, {1'b0, 3'b000, 4'd6, 16'h0F0F}, "R7/R5 readback then overflow");
    // R8: read pending consumed by a dropped frame
    run_frame(24, 1'b0, {1'b1, 3'b000, 4'd6, 16'h0000}, "R8 zero preload");
    run_frame(5,  1'b0, {1'b0, 3'b000, 4'd1, 16'h0000}, "R7 readback in short frame");
    run_frame(24, 1'b0, {1'b0, 3'b000, 4'd1, 16'h7777}, "R8 pending consumed");
    // R6: drive disabled
    run_frame(24, 1'b1, {1'b0, 3'b000, 4'd4, 16'h9999}, "R6");
    // R4: SCLK and SDI with CS high do nothing
    begin
      int wc0;
      wc0 = wr_cnt; oe_seen = 1'b0;
      for (int i = 0; i < 60; i++) begin
        sdi = 1'($urandom); sclk = ~sclk; idle(4);
      end
      sclk = 1'b0; idle(8);
      chk(wr_cnt == wc0 && !oe_seen, "R4 cs high ignored", {32'(wr_cnt - wc0), 31'h0, oe_seen}, 64'h0);
    end
    // random mix
    for (int k = 0; k < 60; k++) begin
      int n, sel;
      logic [23:0] f;
      sel = int'($urandom_range(0, 9));
      n = (sel < 6) ? 24 : (sel < 8) ? int'($urandom_range(25, 60)) : int'($urandom_range(1, 23));
      f = 24'($urandom);
      run_frame(n, ($urandom_range(0, 7) == 0), f, "R5/R7/R8 random sdo stream");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule